// File: doc/BRIEF.md
# Aliased Integer Register File

This block holds the 64 general registers of a 64-bit integer core. Each register is 64 bits wide. The block has two combinational read ports and one full-width write port. It also serves a legacy 32-bit instruction set through narrow views. In that instruction set, the old special registers are not separate flops. Each one is a field inside a fixed general register:

- a base pointer, a vector base and a return address, each a 32-bit word;
- a multiply accumulator, split into two 32-bit halves;
- a one-bit condition flag.

Each view has its own rule for how a write merges with the register that holds it.

A 32-bit compatibility port reads the low word of any register. It writes a word sign-extended to 64 bits. A separate control-register space sits beside the general registers. Index 0 of that space is a 32-bit status register, which has single-bit setters for three flags. The other control indices are plain 64-bit storage.

Index 63 is the hardwired zero register. When writes from different sources name the same register in one cycle, a fixed priority decides which one lands. The block reports such a clash on an output.

Top module: `alias_regfile`

## Requirements
- R1: The read ports return the stored 64-bit value combinationally. A write lands on the rising clock edge. A read in the same cycle as a write to that register returns the old value.
- R2: Register 63 always reads as zero on every read port and every view. Writes to register 63 from any source are discarded.
- R3: The compatibility read returns bits 31:0 of the selected register. The compatibility write stores its 32-bit value sign-extended to 64 bits.
- R4: The base, vector base and return views live in registers 16, 20 and 18. Each reads bits 31:0 of its register. A view write stores the sign-extended 32-bit value into the whole register. The view select encodes base=0, vector base=1, return=2.
- R5: The accumulator lives in register 17. Its high half is bits 63:32 (select 3) and its low half is bits 31:0 (select 4). Writing one half leaves the other half unchanged.
- R6: The condition flag is bit 0 of register 19 (select 5). A write of this view stores bit 0 of the view data and keeps bits 63:1. Selects 6 and 7 write nothing.
- R7: Control index 0 reads as the 32-bit status register, zero-extended to 64 bits. A control write to index 0 stores bits 31:0 of the write data into the status register. Every other control index is ordinary 64-bit storage.
- R8: The flag setter changes exactly one status bit: saturate is bit 1 (select 0), Q is bit 8 (select 1) and M is bit 9 (select 2). Select 3 does nothing. A control write to index 0 in the same cycle wins over the setter.
- R9: When enabled writes name the same general register, the main port beats the compatibility port, and the compatibility port beats the view write. The losing write is dropped entirely. In that cycle the conflict output is high, combinationally.
- R10: Reset clears every general register, every control register and the status register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 6 | Read port A index |
| rdDataA | output | 64 | Read port A data |
| rdAddrB | input | 6 | Read port B index |
| rdDataB | output | 64 | Read port B data |
| wrEn | input | 1 | Main write enable |
| wrAddr | input | 6 | Main write index |
| wrData | input | 64 | Main write data |
| cmpRdAddr | input | 6 | Compatibility read index |
| cmpRdData | output | 32 | Low word of the selected register |
| cmpWrEn | input | 1 | Compatibility write enable |
| cmpWrAddr | input | 6 | Compatibility write index |
| cmpWrData | input | 32 | Word to sign-extend and store |
| viewWrEn | input | 1 | View write enable |
| viewSel | input | 3 | View select (see R4 to R6) |
| viewWrData | input | 32 | View write data |
| baseView | output | 32 | Base pointer view |
| vbaseView | output | 32 | Vector base view |
| retView | output | 32 | Return address view |
| accHiView | output | 32 | Accumulator high half |
| accLoView | output | 32 | Accumulator low half |
| condView | output | 1 | Condition flag |
| crRdAddr | input | 6 | Control read index |
| crRdData | output | 64 | Control read data |
| crWrEn | input | 1 | Control write enable |
| crWrAddr | input | 6 | Control write index |
| crWrData | input | 64 | Control write data |
| statusView | output | 32 | Status register |
| flagWrEn | input | 1 | Flag setter enable |
| flagSel | input | 2 | Flag select (see R8) |
| flagVal | input | 1 | New flag value |
| wrConflict | output | 1 | Same-register write clash this cycle |

## Verification
The bench aims writes at registers 16 to 20 and 63 far more often than at other registers, so clashes and partial merges come up often. A view write that overwrote the whole accumulator or condition register would show up at once as a corrupted other half or corrupted upper bits. A wrong priority would let a view or compatibility write win over the main port, and the stored value would no longer match the model. The bench also writes register 63 and then reads it back. It sets status flags in the same cycle as a control write to index 0, and it writes negative words through the compatibility port. A design that leaked the zero register, let the setter beat the control write, or zero-extended the compatibility write would each produce a mismatch on the next cycle's reads.

// File: rtl/irf_pkg.sv
package irf_pkg;
  localparam int XLEN     = 64;
  localparam int HALF     = 32;
  localparam int IDX_W    = 6;
  localparam int NUM_GR   = 64;
  localparam int ZERO_IDX = 63;
  localparam int BASE_IDX = 16;
  localparam int ACC_IDX  = 17;
  localparam int RET_IDX  = 18;
  localparam int COND_IDX = 19;
  localparam int VBASE_IDX = 20;
  localparam int SAT_BIT  = 1;
  localparam int Q_BIT    = 8;
  localparam int M_BIT    = 9;

  typedef enum logic [2:0] {
    VIEW_BASE   = 3'd0,
    VIEW_VBASE  = 3'd1,
    VIEW_RET    = 3'd2,
    VIEW_ACC_HI = 3'd3,
    VIEW_ACC_LO = 3'd4,
    VIEW_COND   = 3'd5,
    VIEW_RSV6   = 3'd6,
    VIEW_RSV7   = 3'd7
  } view_e;

  typedef enum logic [1:0] {
    FLAG_SAT  = 2'd0,
    FLAG_Q    = 2'd1,
    FLAG_M    = 2'd2,
    FLAG_NONE = 2'd3
  } flag_e;

  typedef struct packed {
    logic              mainWe;
    logic [IDX_W-1:0]  mainIdx;
    logic              cmpWe;
    logic [IDX_W-1:0]  cmpIdx;
    logic              viewWe;
    logic [IDX_W-1:0]  viewIdx;
    view_e             viewKind;
    logic              crWe;
    logic              srFromCr;
    logic              flagWe;
    flag_e             flagKind;
  } strobe_t;
endpackage

// File: rtl/irf_ctrl.sv
module irf_ctrl
  import irf_pkg::*;
#(
  parameter int CR_IDX_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrAddr,
  input  logic                cmpWrEn,
  input  logic [IDX_W-1:0]    cmpWrAddr,
  input  logic                viewWrEn,
  input  view_e               viewSel,
  input  logic                crWrEn,
  input  logic [CR_IDX_W-1:0] crWrAddr,
  input  logic                flagWrEn,
  input  flag_e               flagSel,
  output strobe_t             strobe,
  output logic                wrConflict
);
  logic [IDX_W-1:0] viewTarget;
  logic             viewValid;
  logic             mainCmpSame;
  logic             mainViewSame;
  logic             cmpViewSame;
  logic             crHitsSr;

  always_comb begin
    viewValid  = 1'b1;
    viewTarget = IDX_W'(BASE_IDX);
    unique case (viewSel)
      VIEW_BASE:   viewTarget = IDX_W'(BASE_IDX);
      VIEW_VBASE:  viewTarget = IDX_W'(VBASE_IDX);
      VIEW_RET:    viewTarget = IDX_W'(RET_IDX);
      VIEW_ACC_HI: viewTarget = IDX_W'(ACC_IDX);
      VIEW_ACC_LO: viewTarget = IDX_W'(ACC_IDX);
      VIEW_COND:   viewTarget = IDX_W'(COND_IDX);
      default:     viewValid  = 1'b0;
    endcase
  end

  assign mainCmpSame  = wrEn && cmpWrEn && (wrAddr == cmpWrAddr);
  assign mainViewSame = wrEn && viewWrEn && viewValid && (wrAddr == viewTarget);
  assign cmpViewSame  = cmpWrEn && viewWrEn && viewValid && (cmpWrAddr == viewTarget);
  assign crHitsSr     = crWrEn && (crWrAddr == '0);

  always_comb begin
    strobe          = '0;
    strobe.mainIdx  = wrAddr;
    strobe.cmpIdx   = cmpWrAddr;
    strobe.viewIdx  = viewTarget;
    strobe.viewKind = viewSel;
    strobe.flagKind = flagSel;
    strobe.mainWe   = wrEn && (wrAddr != IDX_W'(ZERO_IDX));
    strobe.cmpWe    = cmpWrEn && !mainCmpSame && (cmpWrAddr != IDX_W'(ZERO_IDX));
    strobe.viewWe   = viewWrEn && viewValid && !mainViewSame && !cmpViewSame;
    strobe.srFromCr = crHitsSr;
    strobe.crWe     = crWrEn && !crHitsSr;
    strobe.flagWe   = flagWrEn && (flagSel != FLAG_NONE) && !crHitsSr;
  end

  assign wrConflict = mainCmpSame || mainViewSame || cmpViewSame;

  // R9: at most one write source may claim a given register per cycle
  p_one_writer_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mainWe && strobe.cmpWe) |-> (strobe.mainIdx != strobe.cmpIdx));
  p_view_yields_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.viewWe |-> !((strobe.mainWe && strobe.mainIdx == strobe.viewIdx) ||
                        (strobe.cmpWe && strobe.cmpIdx == strobe.viewIdx)));
  // R8: control write to status beats the flag setter
  p_cr_beats_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.srFromCr |-> !strobe.flagWe);
endmodule

// File: rtl/irf_datapath.sv
module irf_datapath
  import irf_pkg::*;
#(
  parameter int CR_COUNT = 64,
  parameter int CR_IDX_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [IDX_W-1:0]    rdAddrA,
  output logic [XLEN-1:0]     rdDataA,
  input  logic [IDX_W-1:0]    rdAddrB,
  output logic [XLEN-1:0]     rdDataB,
  input  logic [XLEN-1:0]     wrData,
  input  logic [IDX_W-1:0]    cmpRdAddr,
  output logic [HALF-1:0]     cmpRdData,
  input  logic [HALF-1:0]     cmpWrData,
  input  logic [HALF-1:0]     viewWrData,
  output logic [HALF-1:0]     baseView,
  output logic [HALF-1:0]     vbaseView,
  output logic [HALF-1:0]     retView,
  output logic [HALF-1:0]     accHiView,
  output logic [HALF-1:0]     accLoView,
  output logic                condView,
  input  logic [CR_IDX_W-1:0] crRdAddr,
  output logic [XLEN-1:0]     crRdData,
  input  logic [CR_IDX_W-1:0] crWrAddr,
  input  logic [XLEN-1:0]     crWrData,
  output logic [HALF-1:0]     statusView,
  input  logic                flagVal
);
  logic [XLEN-1:0] grMem [NUM_GR];
  logic [XLEN-1:0] crMem [CR_COUNT];
  logic [HALF-1:0] srReg;

  logic [XLEN-1:0] viewOld;
  logic [XLEN-1:0] viewMerged;
  logic [XLEN-1:0] cmpExt;
  logic [HALF-1:0] flagMask;
  logic [HALF-1:0] srNext;

  function automatic logic [XLEN-1:0] readGr(input logic [IDX_W-1:0] idx,
                                             input logic [XLEN-1:0] val);
    return (idx == IDX_W'(ZERO_IDX)) ? '0 : val;
  endfunction

  assign viewOld = grMem[strobe.viewIdx];
  assign cmpExt  = {{(XLEN-HALF){cmpWrData[HALF-1]}}, cmpWrData};

  always_comb begin
    unique case (strobe.viewKind)
      VIEW_ACC_HI: viewMerged = {viewWrData, viewOld[HALF-1:0]};
      VIEW_ACC_LO: viewMerged = {viewOld[XLEN-1:HALF], viewWrData};
      VIEW_COND:   viewMerged = {viewOld[XLEN-1:1], viewWrData[0]};
      default:     viewMerged = {{(XLEN-HALF){viewWrData[HALF-1]}}, viewWrData};
    endcase
  end

  always_comb begin
    unique case (strobe.flagKind)
      FLAG_SAT: flagMask = HALF'(1) << SAT_BIT;
      FLAG_Q:   flagMask = HALF'(1) << Q_BIT;
      FLAG_M:   flagMask = HALF'(1) << M_BIT;
      default:  flagMask = '0;
    endcase
    srNext = (srReg & ~flagMask) | (flagVal ? flagMask : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_GR; i++) grMem[i] <= '0;
      for (int j = 0; j < CR_COUNT; j++) crMem[j] <= '0;
      srReg <= '0;
    end else begin
      for (int i = 0; i < NUM_GR; i++) begin
        if (strobe.mainWe && strobe.mainIdx == IDX_W'(i))
          grMem[i] <= wrData;
        else if (strobe.cmpWe && strobe.cmpIdx == IDX_W'(i))
          grMem[i] <= cmpExt;
        else if (strobe.viewWe && strobe.viewIdx == IDX_W'(i))
          grMem[i] <= viewMerged;
      end
      if (strobe.crWe && int'(crWrAddr) < CR_COUNT)
        crMem[crWrAddr] <= crWrData;
      if (strobe.srFromCr)
        srReg <= crWrData[HALF-1:0];
      else if (strobe.flagWe)
        srReg <= srNext;
    end
  end

  assign rdDataA   = readGr(rdAddrA, grMem[rdAddrA]);
  assign rdDataB   = readGr(rdAddrB, grMem[rdAddrB]);
  assign cmpRdData = grMem[cmpRdAddr][HALF-1:0] &
                     {HALF{cmpRdAddr != IDX_W'(ZERO_IDX)}};

  assign baseView   = grMem[BASE_IDX][HALF-1:0];
  assign vbaseView  = grMem[VBASE_IDX][HALF-1:0];
  assign retView    = grMem[RET_IDX][HALF-1:0];
  assign accHiView  = grMem[ACC_IDX][XLEN-1:HALF];
  assign accLoView  = grMem[ACC_IDX][HALF-1:0];
  assign condView   = grMem[COND_IDX][0];
  assign statusView = srReg;

  always_comb begin
    if (crRdAddr == '0)
      crRdData = {{(XLEN-HALF){1'b0}}, srReg};
    else if (int'(crRdAddr) < CR_COUNT)
      crRdData = crMem[crRdAddr];
    else
      crRdData = '0;
  end

  // R2: the zero register never takes a value
  p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rstN)
    grMem[ZERO_IDX] == '0);
  // R3: compatibility writes land sign-extended
  p_cmp_sext_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpWe |=> grMem[$past(strobe.cmpIdx)] ==
      {{(XLEN-HALF){$past(cmpWrData[HALF-1])}}, $past(cmpWrData)});
  // R5: high-half write keeps the low half
  p_acc_hi_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.viewWe && strobe.viewKind == VIEW_ACC_HI) |=>
      grMem[ACC_IDX][HALF-1:0] == $past(grMem[ACC_IDX][HALF-1:0]));
  // R5: low-half write keeps the high half
  p_acc_lo_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.viewWe && strobe.viewKind == VIEW_ACC_LO) |=>
      grMem[ACC_IDX][XLEN-1:HALF] == $past(grMem[ACC_IDX][XLEN-1:HALF]));
  // R6: condition write keeps bits 63:1
  p_cond_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.viewWe && strobe.viewKind == VIEW_COND) |=>
      grMem[COND_IDX][XLEN-1:1] == $past(grMem[COND_IDX][XLEN-1:1]));
  // R8: a flag setter touches at most one status bit
  p_flag_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagWe |=> $countones(srReg ^ $past(srReg)) <= 1);
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import irf_pkg::*;
#(
  parameter int CR_COUNT = 64,
  localparam int CR_IDX_W = $clog2(CR_COUNT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_W-1:0]    rdAddrA,
  output logic [XLEN-1:0]     rdDataA,
  input  logic [IDX_W-1:0]    rdAddrB,
  output logic [XLEN-1:0]     rdDataB,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrAddr,
  input  logic [XLEN-1:0]     wrData,
  input  logic [IDX_W-1:0]    cmpRdAddr,
  output logic [HALF-1:0]     cmpRdData,
  input  logic                cmpWrEn,
  input  logic [IDX_W-1:0]    cmpWrAddr,
  input  logic [HALF-1:0]     cmpWrData,
  input  logic                viewWrEn,
  input  logic [2:0]          viewSel,
  input  logic [HALF-1:0]     viewWrData,
  output logic [HALF-1:0]     baseView,
  output logic [HALF-1:0]     vbaseView,
  output logic [HALF-1:0]     retView,
  output logic [HALF-1:0]     accHiView,
  output logic [HALF-1:0]     accLoView,
  output logic                condView,
  input  logic [CR_IDX_W-1:0] crRdAddr,
  output logic [XLEN-1:0]     crRdData,
  input  logic                crWrEn,
  input  logic [CR_IDX_W-1:0] crWrAddr,
  input  logic [XLEN-1:0]     crWrData,
  output logic [HALF-1:0]     statusView,
  input  logic                flagWrEn,
  input  logic [1:0]          flagSel,
  input  logic                flagVal,
  output logic                wrConflict
);
  strobe_t strobe;

  irf_ctrl #(.CR_IDX_W(CR_IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .cmpWrEn    (cmpWrEn),
    .cmpWrAddr  (cmpWrAddr),
    .viewWrEn   (viewWrEn),
    .viewSel    (view_e'(viewSel)),
    .crWrEn     (crWrEn),
    .crWrAddr   (crWrAddr),
    .flagWrEn   (flagWrEn),
    .flagSel    (flag_e'(flagSel)),
    .strobe     (strobe),
    .wrConflict (wrConflict)
  );

  irf_datapath #(.CR_COUNT(CR_COUNT), .CR_IDX_W(CR_IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdAddrA    (rdAddrA),
    .rdDataA    (rdDataA),
    .rdAddrB    (rdAddrB),
    .rdDataB    (rdDataB),
    .wrData     (wrData),
    .cmpRdAddr  (cmpRdAddr),
    .cmpRdData  (cmpRdData),
    .cmpWrData  (cmpWrData),
    .viewWrData (viewWrData),
    .baseView   (baseView),
    .vbaseView  (vbaseView),
    .retView    (retView),
    .accHiView  (accHiView),
    .accLoView  (accLoView),
    .condView   (condView),
    .crRdAddr   (crRdAddr),
    .crRdData   (crRdData),
    .crWrAddr   (crWrAddr),
    .crWrData   (crWrData),
    .statusView (statusView),
    .flagVal    (flagVal)
  );
endmodule

// File: tb/alias_regfile_tb.sv
module alias_regfile_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  rdAddrA, rdAddrB, wrAddr, cmpRdAddr, cmpWrAddr, crRdAddr, crWrAddr;
  logic [63:0] rdDataA, rdDataB, wrData, crRdData, crWrData;
  logic [31:0] cmpRdData, cmpWrData, viewWrData;
  logic [31:0] baseView, vbaseView, retView, accHiView, accLoView, statusView;
  logic        wrEn, cmpWrEn, viewWrEn, crWrEn, flagWrEn, flagVal, condView, wrConflict;
  logic [2:0]  viewSel;
  logic [1:0]  flagSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] mGr [64];
  logic [63:0] mCr [64];
  logic [31:0] mSr;

  always #10 clk = ~clk;

  alias_regfile u_dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mRead(input logic [5:0] a);
    return (a == 6'd63) ? 64'd0 : mGr[a];
  endfunction

  function automatic int viewReg(input logic [2:0] s);
    case (s)
      3'd0: return 16;
      3'd1: return 20;
      3'd2: return 18;
      3'd3, 3'd4: return 17;
      3'd5: return 19;
      default: return -1;
    endcase
  endfunction

  function automatic logic expConflict();
    int v;
    bit c;
    v = viewReg(viewSel);
    c = wrEn && cmpWrEn && (wrAddr == cmpWrAddr);
    if (viewWrEn && v >= 0) begin
      if (wrEn && int'(wrAddr) == v) c = 1;
      if (cmpWrEn && int'(cmpWrAddr) == v) c = 1;
    end
    return c;
  endfunction

  task automatic compareAll();
    chk(rdAddrA == 63 ? "R2" : "R1", "rdDataA", rdDataA, mRead(rdAddrA));
    chk(rdAddrB == 63 ? "R2" : "R1", "rdDataB", rdDataB, mRead(rdAddrB));
    chk("R3", "cmpRdData", {32'd0, cmpRdData}, {32'd0, mRead(cmpRdAddr)[31:0]});
    chk("R4", "baseView", {32'd0, baseView}, {32'd0, mGr[16][31:0]});
    chk("R4", "vbaseView", {32'd0, vbaseView}, {32'd0, mGr[20][31:0]});
    chk("R4", "retView", {32'd0, retView}, {32'd0, mGr[18][31:0]});
    chk("R5", "accHiView", {32'd0, accHiView}, {32'd0, mGr[17][63:32]});
    chk("R5", "accLoView", {32'd0, accLoView}, {32'd0, mGr[17][31:0]});
    chk("R6", "condView", {63'd0, condView}, {63'd0, mGr[19][0]});
    chk("R7", "crRdData", crRdData, crRdAddr == 0 ? {32'd0, mSr} : mCr[crRdAddr]);
    chk("R8", "statusView", {32'd0, statusView}, {32'd0, mSr});
    chk("R9", "wrConflict", {63'd0, wrConflict}, {63'd0, expConflict()});
  endtask

  task automatic updateModel();
    int v;
    v = viewReg(viewSel);
    // lowest priority first so later sources overwrite
    if (viewWrEn && v >= 0) begin
      case (viewSel)
        3'd3: mGr[v][63:32] = viewWrData;
        3'd4: mGr[v][31:0]  = viewWrData;
        3'd5: mGr[v][0]     = viewWrData[0];
        default: mGr[v] = {{32{viewWrData[31]}}, viewWrData};
      endcase
    end
    if (cmpWrEn && cmpWrAddr != 63) mGr[cmpWrAddr] = {{32{cmpWrData[31]}}, cmpWrData};
    if (cmpWrEn && wrEn && cmpWrAddr == wrAddr && wrAddr != 63) mGr[wrAddr] = wrData;
    if (wrEn && wrAddr != 63) mGr[wrAddr] = wrData;
    if (flagWrEn) begin
      case (flagSel)
        2'd0: mSr[1] = flagVal;
        2'd1: mSr[8] = flagVal;
        2'd2: mSr[9] = flagVal;
        default: ;
      endcase
    end
    if (crWrEn) begin
      if (crWrAddr == 0) mSr = crWrData[31:0];
      else mCr[crWrAddr] = crWrData;
    end
  endtask

  task automatic idleIn();
    wrEn = 0; cmpWrEn = 0; viewWrEn = 0; crWrEn = 0; flagWrEn = 0;
    wrAddr = 0; cmpWrAddr = 0; crWrAddr = 0; viewSel = 0; flagSel = 0; flagVal = 0;
    wrData = 0; cmpWrData = 0; viewWrData = 0; crWrData = 0;
  endtask

  task automatic runCycle();
    #5;
    compareAll();
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  function automatic logic [5:0] pickIdx();
    case ($urandom % 10)
      0: return 6'd16;
      1: return 6'd17;
      2: return 6'd18;
      3: return 6'd19;
      4: return 6'd20;
      5: return 6'd63;
      6: return 6'd0;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mGr[i] = 0; mCr[i] = 0; end
    mSr = 0;
    rstN = 0;
    idleIn();
    rdAddrA = 6'd5; rdAddrB = 6'd17; cmpRdAddr = 6'd19; crRdAddr = 6'd0;
    repeat (3) @(negedge clk);
    // R10: everything reads zero during reset
    compareAll();
    rstN = 1;
    @(negedge clk);

    // R1: same-cycle read of a written register shows the old value
    wrEn = 1; wrAddr = 6'd5; wrData = 64'hDEAD_BEEF_0123_4567; rdAddrA = 6'd5;
    runCycle();
    idleIn(); runCycle();
    // R2: write to register 63 is discarded
    wrEn = 1; wrAddr = 6'd63; wrData = '1; rdAddrA = 6'd63; runCycle();
    idleIn(); runCycle();
    // R3: negative word sign-extends
    cmpWrEn = 1; cmpWrAddr = 6'd7; cmpWrData = 32'h8000_0001; rdAddrB = 6'd7; cmpRdAddr = 6'd7;
    runCycle(); idleIn(); runCycle();
    // R4: each 32-bit view
    for (int s = 0; s < 3; s++) begin
      viewWrEn = 1; viewSel = 3'(s); viewWrData = 32'hF000_0000 + s; runCycle();
    end
    idleIn(); rdAddrA = 6'd16; rdAddrB = 6'd20; runCycle();
    // R5: both accumulator halves, each keeps the other
    wrEn = 1; wrAddr = 6'd17; wrData = 64'h1111_2222_3333_4444; runCycle(); idleIn();
    viewWrEn = 1; viewSel = 3'd3; viewWrData = 32'hAAAA_5555; runCycle();
    viewSel = 3'd4; viewWrData = 32'h0F0F_F0F0; rdAddrB = 6'd17; runCycle();
    idleIn(); runCycle();
    // R6: condition bit keeps bits 63:1; reserved selects write nothing
    wrEn = 1; wrAddr = 6'd19; wrData = '1; runCycle(); idleIn();
    viewWrEn = 1; viewSel = 3'd5; viewWrData = 32'd0; rdAddrA = 6'd19; runCycle();
    viewSel = 3'd6; viewWrData = '1; runCycle();
    idleIn(); runCycle();
    // R7 and R8: control writes, flag setters, clash at index 0
    crWrEn = 1; crWrAddr = 6'd4; crWrData = 64'h0123_4567_89AB_CDEF; crRdAddr = 6'd4; runCycle();
    idleIn(); runCycle();
    flagWrEn = 1; flagVal = 1; flagSel = 2'd0; crRdAddr = 6'd0; runCycle();
    flagSel = 2'd1; runCycle(); flagSel = 2'd2; runCycle();
    flagSel = 2'd1; flagVal = 0; crWrEn = 1; crWrAddr = 6'd0; crWrData = 64'hFFFF_FFFF_0000_0100;
    runCycle(); idleIn(); runCycle();
    // R9: three sources on register 17 at once
    wrEn = 1; wrAddr = 6'd17; wrData = 64'h7777_0000_7777_0000;
    cmpWrEn = 1; cmpWrAddr = 6'd17; cmpWrData = 32'h1234_5678;
    viewWrEn = 1; viewSel = 3'd4; viewWrData = 32'h9999_9999; runCycle();
    wrEn = 0; cmpWrData = 32'hFFFF_0000; runCycle();
    idleIn(); runCycle();

    // biased random traffic across all ports
    for (int n = 0; n < 4000; n++) begin
      wrEn = ($urandom % 3) == 0; wrAddr = pickIdx(); wrData = {$urandom, $urandom};
      cmpWrEn = ($urandom % 3) == 0; cmpWrAddr = pickIdx(); cmpWrData = $urandom;
      viewWrEn = ($urandom % 2) == 0; viewSel = 3'($urandom); viewWrData = $urandom;
      crWrEn = ($urandom % 4) == 0; crWrAddr = ($urandom % 2) ? 6'd0 : 6'($urandom);
      crWrData = {$urandom, $urandom};
      flagWrEn = ($urandom % 2) == 0; flagSel = 2'($urandom); flagVal = 1'($urandom);
      rdAddrA = pickIdx(); rdAddrB = pickIdx(); cmpRdAddr = pickIdx();
      crRdAddr = ($urandom % 2) ? 6'd0 : 6'($urandom);
      runCycle();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule